// File: doc/BRIEF.md
# Reloading Microsecond Interval Timer

This block is a periodic interval timer. Software places a 16-bit count into two byte-wide latches (a low byte and a high byte) through a small register port, then writes a start register. From that moment the timer counts microsecond ticks. The tick comes from an internal divider that turns `TICK_DIV` clock cycles into one tick. The count used is the 16-bit latch value with its four low bits dropped, so the period in microseconds is `{high, low} >> 4`.

When the count runs out, the block raises `expire_pulse` for one clock cycle. This pulse is the event that the interrupt controller records in its status bit 6; masking happens in the controller, not here. After each expiry the timer reloads from the latches as they stand at that moment and keeps running. A new start write at any time restarts the countdown and the tick divider.

The control is a two-state machine. `ST_IDLE` holds after reset. The transition *start* (a start write) leads to `ST_RUN`. Inside `ST_RUN` there are three transitions: *restart* (a start write reloads the count), *step* (a tick with more than one unit left decrements the count) and *expire* (a tick with at most one unit left pulses and reloads).

Top module: `usec_reload_timer`

## Requirements
- R1: After reset both latches read 0, the machine is in `ST_IDLE`, and `expire_pulse` stays low until the first start write.
- R2: A write updates the low latch at address 0x50 or the high latch at address 0x54 only when `wr_en` and `wr_byte_en` are both high. A write with `wr_byte_en` low, or a write to any other address, leaves both latches unchanged.
- R3: `rd_data` shows the low latch when `addr` is 0x50 and the high latch when `addr` is 0x54. It shows 0 for every other address.
- R4: A write to address 0x58 starts the countdown. The data value and `wr_byte_en` do not matter. The write also clears the tick divider.
- R5: For a period P = `{high, low} >> 4` with P ≥ 1, the first `expire_pulse` comes P×`TICK_DIV` cycles after the clock edge that takes the start write.
- R6: A period of 0 behaves the same as a period of 1. The timer expires on the first tick (`TICK_DIV` cycles) and again on every tick after that, and never stalls.
- R7: `expire_pulse` is high for exactly one clock cycle per expiry.
- R8: After an expiry the timer reloads by itself, so expiries repeat every P×`TICK_DIV` cycles without further writes.
- R9: Latch writes made while the timer runs do not change the countdown in progress. They take effect at the next reload or the next start write.
- R10: A start write while the timer runs discards the remaining count. The next expiry comes P×`TICK_DIV` cycles after the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address, used for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_byte_en | input | 1 | Lane enable for the data byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| expire_pulse | output | 1 | One-cycle expiry event |

## Verification
Assertions check the following on every cycle:
- The machine is quiet while idle.
- A start write loads the count.
- The count steps down by one on each tick and holds between ticks.
- An expiry reloads the count from the latches.
- The pulse lasts one cycle.
- The latches do not change on a write that is gated off or goes to another address.

The following can only be shown by the bench's scenarios, which time pulses against a cycle counter:
- The end-to-end period in clock cycles for several latch values, including 0, 1 and the maximum.
- A latch change made mid-period that appears only on the following period.
- A restart that moves the next expiry.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_LATCH_LO = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_LATCH_HI = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_START    = 8'h58;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pres_q;

            always_ff @(posedge clk) begin
                if (!rst_n)              pres_q <= '0;
                else if (clear_i)        pres_q <= '0;
                else if (pres_q == LAST) pres_q <= '0;
                else                     pres_q <= pres_q + PW'(1);
            end

            assign tick_o = (pres_q == LAST);

            AST_TICK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> !tick_o); // R4
        end
    endgenerate
endmodule

// File: rtl/usec_latch_regs.sv
module usec_latch_regs
    import usec_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SHIFT  = 4,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_byte_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  period_o,
    output logic              start_o
);
    logic [DATA_W-1:0] lo_q, hi_q;
    logic wr_lane;

    assign wr_lane = wr_en && wr_byte_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lane && addr == OFS_LATCH_LO) lo_q <= wr_data;
            if (wr_lane && addr == OFS_LATCH_HI) hi_q <= wr_data;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_LATCH_LO: rd_data = lo_q;
            OFS_LATCH_HI: rd_data = hi_q;
            default:      rd_data = '0;
        endcase
    end

    assign period_o = {hi_q, lo_q} >> SHIFT;
    assign start_o  = wr_en && (addr == OFS_START);

    AST_LATCH_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!wr_byte_en || (addr != OFS_LATCH_LO && addr != OFS_LATCH_HI)))
        |=> ($stable(lo_q) && $stable(hi_q))); // R2
endmodule

// File: rtl/usec_timer_core.sv
module usec_timer_core
    import usec_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             expire_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic             expire_q, expire_d;

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        expire_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_RUN;
                    remain_d = period_i;
                end
            end
            ST_RUN: begin
                if (start_i) begin
                    remain_d = period_i;
                end else if (tick_i) begin
                    if (remain_q <= CNT_W'(1)) begin
                        expire_d = 1'b1;
                        remain_d = period_i;
                    end else begin
                        remain_d = remain_q - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            expire_q <= 1'b0;
        end else begin
            remain_q <= remain_d;
            expire_q <= expire_d;
        end
    end

    assign expire_o = expire_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !expire_q); // R1
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_RUN && remain_q == $past(period_i) && !expire_q)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && !start_i && remain_q > CNT_W'(1))
        |=> (remain_q == $past(remain_q) - CNT_W'(1) && !expire_q)); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tick_i && !start_i) |=> ($stable(remain_q) && !expire_q)); // R9
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && !start_i && remain_q <= CNT_W'(1))
        |=> (expire_q && remain_q == $past(period_i))); // R8

    generate
        if (TICK_DIV > 1) begin : g_pulse_chk
            AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                expire_q |=> !expire_q); // R7
        end
    endgenerate
endmodule

// File: rtl/usec_reload_timer.sv
module usec_reload_timer
    import usec_timer_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SHIFT    = 4,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_byte_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              expire_pulse
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] period;
    logic             start;
    logic             tick;

    usec_latch_regs #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .wr_byte_en (wr_byte_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .period_o   (period),
        .start_o    (start)
    );

    usec_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start),
        .tick_o  (tick)
    );

    usec_timer_core #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tick_i   (tick),
        .period_i (period),
        .expire_o (expire_pulse)
    );
endmodule

// File: tb/usec_reload_timer_bench.sv
module usec_reload_timer_bench;
    localparam int DIV = 4;
    // {latch value, expected period in cycles = (latch >> 4) * DIV, min DIV}
    localparam logic [31:0] VEC [0:5] = '{
        {16'h0030, 16'd12},    // R5
        {16'h0005, 16'd4},     // R6 period 0
        {16'h001F, 16'd4},     // R6 period 1
        {16'h0100, 16'd64},    // R5
        {16'h0A47, 16'd656},   // R5 low nibble dropped
        {16'hFFFF, 16'd16380}  // R5 maximum
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic       wr_en, wr_byte_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       expire_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    usec_reload_timer u_usec_reload_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_byte_en(wr_byte_en), .wr_data(wr_data), .rd_data(rd_data),
        .expire_pulse(expire_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic lane, output int t);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; wr_byte_en = lane;
        @(negedge clk);
        t = cyc;
        wr_en = 1'b0; wr_byte_en = 1'b0; addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic wait_pulse(input int limit, output int t);
        t = -1;
        for (int n = 0; n < limit; n++) begin
            @(negedge clk);
            if (expire_pulse) begin
                t = cyc;
                break;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, tg, tp, v, pulses;
        rst_n = 1'b0; addr = 8'h00; wr_en = 1'b0; wr_byte_en = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R3: reset state and silence
        rd(8'h50, v); chk("R1 low latch after reset", v, 0);
        rd(8'h54, v); chk("R1 high latch after reset", v, 0);
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (expire_pulse) pulses++;
        end
        chk("R1 no pulse before start", pulses, 0);

        // R2: gated and misdirected writes
        wr(8'h50, 8'hAA, 1'b0, t);
        rd(8'h50, v); chk("R2 lane off ignored", v, 0);
        wr(8'h5C, 8'h77, 1'b1, t);
        rd(8'h50, v); chk("R2 other address low", v, 0);
        rd(8'h54, v); chk("R2 other address high", v, 0);
        rd(8'h5C, v); chk("R3 unmapped reads zero", v, 0);

        // R3: readback
        wr(8'h50, 8'h34, 1'b1, t);
        wr(8'h54, 8'h12, 1'b1, t);
        rd(8'h50, v); chk("R3 low readback", v, 'h34);
        rd(8'h54, v); chk("R3 high readback", v, 'h12);

        // R5 R6 R7 R8: vector table
        for (int i = 0; i < 6; i++) begin
            wr(8'h50, VEC[i][23:16], 1'b1, t);
            wr(8'h54, VEC[i][31:24], 1'b1, t);
            wr(8'h58, 8'h00, 1'b1, tg);
            wait_pulse(20000, tp);
            chk("R5 first period", tp - tg, int'(VEC[i][15:0]));
            @(negedge clk);
            chk("R7 pulse one cycle", int'(expire_pulse), 0);
            tg = tp;
            wait_pulse(20000, tp);
            chk("R8 reload period", tp - tg, int'(VEC[i][15:0]));
        end

        // R9 with R4: start with lane off, then a mid-period latch change
        wr(8'h54, 8'h00, 1'b1, t);
        wr(8'h50, 8'hA0, 1'b1, t);
        wr(8'h58, 8'h5A, 1'b0, tg);
        wr(8'h50, 8'h50, 1'b1, t);
        wait_pulse(1000, tp);
        chk("R9 running period kept", tp - tg, 40);
        tg = tp;
        wait_pulse(1000, tp);
        chk("R9 new value after reload", tp - tg, 20);

        // R10: restart mid-period
        wr(8'h50, 8'hA0, 1'b1, t);
        wr(8'h58, 8'h00, 1'b1, tg);
        repeat (20) @(negedge clk);
        wr(8'h58, 8'h00, 1'b1, tg);
        wait_pulse(1000, tp);
        chk("R10 restart moves expiry", tp - tg, 40);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule